// File: doc/BRIEF.md
# Mixed-Length Instruction Stream Aligner

This block sits on the fetch side of a processor front end. Instruction memory hands it 32-bit words in address order. The block breaks each word into its two halfwords and keeps them in a small queue. From that queue it emits whole instructions, one per handshake. Each instruction is either a single 16-bit halfword or a pair of consecutive halfwords forming a 32-bit instruction.

The length of an instruction is decided from the five most significant bits of its first halfword. Three prefix values mark a wide instruction, and every other value marks a narrow one. A wide instruction may begin in the upper halfword of one fetch word and end in the lower halfword of the next. In that case the block holds the first half until the next word arrives.

A flush input restarts the stream at a new branch target. Bit 0 of the target only selects the halfword instruction mode and never reaches the address. When address bit 1 of the target is set, the lower halfword of the first word fetched after the flush is discarded. Every output carries the address of the instruction's first halfword.

Top module: `hsa_stream_aligner`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A head halfword whose bits [15:11] are any value other than 0b11101, 0b11110 or 0b11111 is emitted alone with out_is32 = 0 and out_instr = {16'h0000, halfword}.
- R3: A head halfword whose bits [15:11] are 0b11101, 0b11110 or 0b11111 is emitted together with the next halfword in the stream, with out_is32 = 1 and out_instr = {first halfword, second halfword} (first halfword in bits [31:16]).
- R4: Within an accepted word, bits [15:0] come before bits [31:16] in the instruction stream.
- R5: A wide instruction whose first halfword is the upper half of a word is not emitted (out_valid stays 0) until the following word is accepted.
- R6: out_addr is the byte address of the instruction's first halfword. After each accepted output it advances by 2 for a narrow instruction and by 4 for a wide one.
- R7: A flush discards all buffered halfwords. In the flush cycle in_ready and out_valid are 0, and out_valid stays 0 until a new word has been accepted.
- R8: When bit 1 of the flush target is set, the lower halfword of the first word accepted after the flush is dropped, and the stream begins with that word's upper halfword.
- R9: Bit 0 of the flush target is cleared in the address, so out_addr after a flush equals the target with bit 0 forced to 0.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_instr, out_is32 and out_addr hold their values until the output is taken or a flush arrives.
- R11: in_ready is 0 whenever the queue has room for fewer than two halfwords, so no accepted halfword is ever lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Restart the stream at flush_target |
| flush_target | input | ADDR_W | Branch target byte address; bit 0 is a mode bit and is dropped |
| in_valid | input | 1 | A fetch word is offered |
| in_ready | output | 1 | The block accepts the offered word in this cycle |
| in_word | input | 32 | Fetch word; lower halfword first in the stream |
| out_valid | output | 1 | A whole instruction is presented |
| out_ready | input | 1 | The consumer takes the presented instruction |
| out_is32 | output | 1 | 1 for a 32-bit instruction, 0 for a 16-bit one |
| out_instr | output | 32 | Instruction; a 16-bit instruction is zero-extended |
| out_addr | output | ADDR_W | Byte address of the instruction's first halfword |

## Verification
Two events can fall in the same cycle and need checking. The first is a flush arriving while a fetch word is offered. The bench raises flush and in_valid together, with a marker word on in_word. It checks that in_ready is low in that cycle. It then checks that the first instruction afterwards comes from the next word offered and carries the target address, so the marker word was dropped. The second is a held wide instruction that is still waiting for its second half when a flush arrives. The bench checks that out_valid stays low after the flush and that the first instruction after it starts at the new target.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

   localparam int HW_W   = 16;
   localparam int WORD_W = 32;
   localparam int HW_PER_WORD = WORD_W / HW_W;

   typedef logic [HW_W-1:0]   hw_t;
   typedef logic [WORD_W-1:0] word_t;

   // Prefix codes in bits [15:11] that open a two-halfword instruction.
   localparam logic [4:0] WIDE_PFX_A = 5'b11101;
   localparam logic [4:0] WIDE_PFX_B = 5'b11110;
   localparam logic [4:0] WIDE_PFX_C = 5'b11111;

   function automatic logic opens_wide(input hw_t h);
      logic [4:0] pfx;
      pfx = h[HW_W-1 -: 5];
      return (pfx == WIDE_PFX_A) || (pfx == WIDE_PFX_B) || (pfx == WIDE_PFX_C);
   endfunction

endpackage

// File: rtl/hsa_len_decode.sv
module hsa_len_decode
   import hsa_pkg::*;
(
   input  hw_t        first_hw,
   output logic       is_wide,
   output logic [1:0] hw_need
);

   always_comb begin
      is_wide = opens_wide(first_hw);
      hw_need = is_wide ? 2'd2 : 2'd1;
   end

endmodule

// File: rtl/hsa_hw_queue.sv
module hsa_hw_queue
   import hsa_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CW = $clog2(DEPTH + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic [1:0]    push_n,
   input  hw_t           push_lo,
   input  hw_t           push_hi,
   input  logic [1:0]    pop_n,
   output hw_t           head0,
   output hw_t           head1,
   output logic [CW-1:0] count
);

   hw_t           mem_q [DEPTH];
   hw_t           mem_d [DEPTH];
   logic [CW-1:0] count_q;
   logic [CW-1:0] keep;

   assign keep  = count_q - CW'(pop_n);
   assign count = count_q;
   assign head0 = mem_q[0];
   assign head1 = mem_q[1];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      hw_t from_1;
      hw_t from_2;
      hw_t shifted;

      if (i + 1 < DEPTH) begin : g_s1
         assign from_1 = mem_q[i+1];
      end else begin : g_z1
         assign from_1 = '0;
      end
      if (i + 2 < DEPTH) begin : g_s2
         assign from_2 = mem_q[i+2];
      end else begin : g_z2
         assign from_2 = '0;
      end

      always_comb begin
         case (pop_n)
            2'd1:    shifted = from_1;
            2'd2:    shifted = from_2;
            default: shifted = mem_q[i];
         endcase
         if (CW'(i) < keep)
            mem_d[i] = shifted;
         else if ((CW'(i) == keep) && (push_n != 2'd0))
            mem_d[i] = push_lo;
         else if ((CW'(i) > keep) && (CW'(i) - keep == CW'(1)) && (push_n == 2'd2))
            mem_d[i] = push_hi;
         else
            mem_d[i] = mem_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else begin
         count_q <= keep + CW'(push_n);
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= mem_d[k];
      end
   end

   // R11: the producer side never pushes more than the free room
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && push_n != 2'd0) |-> ({1'b0, keep} + (CW+1)'(push_n) <= (CW+1)'(DEPTH)));

   // R5: the output side never takes halfwords that are not yet stored
   a_r5_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_n != 2'd0) |-> (CW'(pop_n) <= count_q));

endmodule

// File: rtl/hsa_addr_track.sv
module hsa_addr_track #(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic              step_wide,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (load)
         addr_q <= {load_addr[ADDR_W-1:1], 1'b0};
      else if (step)
         addr_q <= addr_q + (step_wide ? ADDR_W'(4) : ADDR_W'(2));
   end

   assign addr = addr_q;

   // R9: a loaded address is always halfword aligned
   a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_q[0] == 1'b0));

endmodule

// File: rtl/hsa_stream_aligner.sv
module hsa_stream_aligner
   import hsa_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_target,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [31:0]       in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_is32,
   output logic [31:0]       out_instr,
   output logic [ADDR_W-1:0] out_addr
);

   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 3) begin : g_bad_depth
      $error("hsa_stream_aligner: DEPTH must be at least 3 to hold a split wide instruction");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("hsa_stream_aligner: ADDR_W must be at least 2");
   end

   hw_t           head0, head1;
   logic [CW-1:0] count;
   logic          head_wide;
   logic [1:0]    need;
   logic          skip_q;
   logic          take_in, take_out;
   logic [1:0]    push_n, pop_n;
   hw_t           push_lo, push_hi;

   // Length of the instruction at the head of the queue
   hsa_len_decode u_len (
      .first_hw (head0),
      .is_wide  (head_wide),
      .hw_need  (need)
   );

   // Input side: room for a whole word, nothing taken during a flush
   assign in_ready = !flush && (count <= CW'(DEPTH - HW_PER_WORD));
   assign take_in  = in_valid && in_ready;

   always_comb begin
      if (!take_in) begin
         push_n  = 2'd0;
         push_lo = in_word[HW_W-1:0];
         push_hi = in_word[WORD_W-1:HW_W];
      end else if (skip_q) begin
         push_n  = 2'd1;
         push_lo = in_word[WORD_W-1:HW_W];
         push_hi = '0;
      end else begin
         push_n  = 2'd2;
         push_lo = in_word[HW_W-1:0];
         push_hi = in_word[WORD_W-1:HW_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       skip_q <= 1'b0;
      else if (flush)   skip_q <= flush_target[1];
      else if (take_in) skip_q <= 1'b0;
   end

   // Output side
   assign out_valid = !flush && (count >= CW'(need));
   assign take_out  = out_valid && out_ready;
   assign pop_n     = take_out ? need : 2'd0;
   assign out_is32  = head_wide;
   assign out_instr = head_wide ? {head0, head1} : {16'h0000, head0};

   hsa_hw_queue #(.DEPTH(DEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (flush),
      .push_n  (push_n),
      .push_lo (push_lo),
      .push_hi (push_hi),
      .pop_n   (pop_n),
      .head0   (head0),
      .head1   (head1),
      .count   (count)
   );

   hsa_addr_track #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (flush),
      .load_addr (flush_target),
      .step      (take_out),
      .step_wide (head_wide),
      .addr      (out_addr)
   );

   // R10: a stalled output holds still unless a flush intervenes
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (flush || (out_valid && $stable(out_instr) && $stable(out_is32) && $stable(out_addr))));

   // R6: the address steps by the size of the instruction just taken
   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !flush) |=>
         (out_addr == $past(out_addr) + ($past(out_is32) ? ADDR_W'(4) : ADDR_W'(2))));

   // R7: nothing is presented in the cycle after a flush
   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

   // R7: no word is accepted while flushing
   a_r7_no_take_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready);

endmodule

// File: tb/tb_hsa_stream_aligner.sv
module tb_hsa_stream_aligner;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic [ADDR_W-1:0] flush_target = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [31:0]       in_word = '0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic              out_is32;
   logic [31:0]       out_instr;
   logic [ADDR_W-1:0] out_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hsa_stream_aligner #(.ADDR_W(ADDR_W), .DEPTH(4)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_target(flush_target),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready), .out_is32(out_is32),
      .out_instr(out_instr), .out_addr(out_addr)
   );

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_flush(input logic [ADDR_W-1:0] tgt);
      @(negedge clk);
      flush = 1'b1;
      flush_target = tgt;
      @(posedge clk);
      #1 flush = 1'b0;
   endtask

   task automatic send_word(input logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic get_out(input string req, input logic [31:0] ins, input logic is32, input logic [ADDR_W-1:0] adr);
      bit seen = 1'b0;
      for (int n = 0; n < 50 && !seen; n++) begin
         @(negedge clk);
         seen = out_valid;
      end
      check(req, "out_valid", 64'(seen), 64'(1));
      check(req, "out_instr", 64'(out_instr), 64'(ins));
      check(req, "out_is32", 64'(out_is32), 64'(is32));
      check(req, "out_addr", 64'(out_addr), 64'(adr));
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1", "out_valid after reset", 64'(out_valid), 64'(0));
      check("R1", "in_ready after reset", 64'(in_ready), 64'(1));
   endtask

   task automatic t_narrow_order;
      do_flush(32'h0000_0100);
      send_word(32'h2001_1000);
      get_out("R4", 32'h0000_1000, 1'b0, 32'h100);
      get_out("R2", 32'h0000_2001, 1'b0, 32'h102);
   endtask

   task automatic t_wide_aligned;
      do_flush(32'h0000_0800);
      send_word(32'h5678_F123);
      get_out("R3", 32'hF123_5678, 1'b1, 32'h800);
   endtask

   task automatic t_straddle;
      do_flush(32'h0000_0200);
      send_word(32'hF800_0011);
      get_out("R2", 32'h0000_0011, 1'b0, 32'h200);
      @(negedge clk);
      check("R5", "held wide half not presented", 64'(out_valid), 64'(0));
      send_word(32'h3333_ABCD);
      get_out("R5", 32'hF800_ABCD, 1'b1, 32'h202);
      get_out("R6", 32'h0000_3333, 1'b0, 32'h206);
   endtask

   task automatic t_prefix_edges;
      do_flush(32'h0000_0700);
      send_word(32'hE800_E7FF);
      get_out("R2", 32'h0000_E7FF, 1'b0, 32'h700);
      send_word(32'h0000_1234);
      get_out("R3", 32'hE800_1234, 1'b1, 32'h702);
      get_out("R6", 32'h0000_0000, 1'b0, 32'h706);
   endtask

   task automatic t_skip_lower;
      do_flush(32'h0000_0302);
      send_word(32'h4444_E999);
      get_out("R8", 32'h0000_4444, 1'b0, 32'h302);
      @(negedge clk);
      check("R8", "dropped halfword never presented", 64'(out_valid), 64'(0));
   endtask

   task automatic t_mode_bit;
      do_flush(32'h0000_0403);
      send_word(32'h5555_F000);
      get_out("R9", 32'h0000_5555, 1'b0, 32'h402);
   endtask

   task automatic t_stall_and_flush;
      logic [31:0] first_ins;
      do_flush(32'h0000_0A00);
      out_ready = 1'b0;
      send_word(32'h1111_2222);
      @(negedge clk);
      first_ins = out_instr;
      check("R10", "stalled out_valid", 64'(out_valid), 64'(1));
      check("R10", "stalled out_instr", 64'(out_instr), 64'(32'h0000_2222));
      send_word(32'h3333_4444);
      @(negedge clk);
      check("R11", "in_ready with full queue", 64'(in_ready), 64'(0));
      check("R10", "out_instr held over stall", 64'(out_instr), 64'(first_ins));
      check("R10", "out_addr held over stall", 64'(out_addr), 64'(32'hA00));
      do_flush(32'h0000_0500);
      @(negedge clk);
      check("R7", "out_valid after flush", 64'(out_valid), 64'(0));
      check("R7", "in_ready after flush", 64'(in_ready), 64'(1));
      out_ready = 1'b1;
      send_word(32'h6666_7777);
      get_out("R7", 32'h0000_7777, 1'b0, 32'h500);
      get_out("R7", 32'h0000_6666, 1'b0, 32'h502);
   endtask

   task automatic t_flush_with_word;
      // flush and an offered word in the same cycle: the word is refused
      do_flush(32'h0000_0B00);
      send_word(32'hF900_0001);
      get_out("R2", 32'h0000_0001, 1'b0, 32'hB00);
      @(negedge clk);
      flush = 1'b1;
      flush_target = 32'h0000_0600;
      in_valid = 1'b1;
      in_word = 32'hDEAD_BEEF;
      #0.5;
      check("R7", "in_ready during flush", 64'(in_ready), 64'(0));
      check("R7", "out_valid during flush", 64'(out_valid), 64'(0));
      @(posedge clk);
      #1 flush = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check("R7", "refused word leaves queue empty", 64'(out_valid), 64'(0));
      send_word(32'h0001_0002);
      get_out("R7", 32'h0000_0002, 1'b0, 32'h600);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_narrow_order();
      t_wide_aligned();
      t_straddle();
      t_prefix_edges();
      t_skip_lower();
      t_mode_bit();
      t_stall_and_flush();
      t_flush_with_word();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule